// File: doc/BRIEF.md
# Blowfish Substitution Table Memory

This block keeps the four 256-entry, 32-bit substitution tables of a single bcrypt core. Every Blowfish round it returns all four table words at once, together with the F-function value built from them. The four tables sit in two true dual-port memories, two tables per memory, and each table fills one half of its memory's address range. No table is held twice. One port of each memory serves one table, so a single read latency yields all four words.

The computation already uses every memory port. The initial table contents therefore enter through a multiplexer on those same ports. A sequential loader reads a host-filled staging memory one word per cycle and writes word i into table i/256 at entry i%256. When the last write has landed, the loader raises a one-cycle done pulse. While loading is in progress, lookup strobes are ignored. Outside loading, the lookup path is fully pipelined and takes a new strobe on every cycle.

Top module: `sbox_lookup_mem`

## Requirements
- R1: After a load, table t (t = 0..3) entry e (e = 0..255) holds staging word t*256 + e.
- R2: A lookup reads four entries. Byte 3 (bits 31:24) of the round input indexes table 0 onto s0_out. Byte 2 (bits 23:16) indexes table 1 onto s1_out. Byte 1 (bits 15:8) indexes table 2 onto s2_out. Byte 0 (bits 7:0) indexes table 3 onto s3_out.
- R3: A strobe sampled at clock edge k produces its four words and out_valid after edge k+1, which is a latency of two cycles. out_valid is high for exactly one cycle per accepted strobe and at no other time.
- R4: Strobes on consecutive cycles are all accepted, and their results come out on consecutive cycles in the same order.
- R5: f_out equals ((s0_out + s1_out) XOR s2_out) + s3_out, with both additions modulo 2^32. It is valid in the same cycle as the four words.
- R6: Once load_start is sampled, the next 1024 consecutive cycles each assert stage_rd, with stage_addr counting from 0 up to 1023. The staging memory returns data one cycle after each read.
- R7: load_done is a single-cycle pulse. It is high in the second cycle after the last staging read.
- R8: A lookup strobe that is sampled after load_start has been accepted, and up to and including the cycle of the last table write, produces no out_valid.
- R9: An asserted rst_n (active low, asynchronous assert, synchronous release) clears out_valid, load_done and stage_rd. Reset leaves the table contents unchanged.
- R10: A load_start that arrives while a load is running is ignored, and the address sequence continues without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, released synchronously inside |
| lookup_strobe | input | 1 | Request a four-table lookup |
| round_in | input | 32 | Round value, one byte per table |
| load_start | input | 1 | Begin loading the tables from staging |
| stage_rd | output | 1 | Staging memory read enable |
| stage_addr | output | 10 | Staging memory word address |
| stage_data | input | 32 | Staging read data, one cycle after stage_rd |
| s0_out | output | 32 | Table 0 word |
| s1_out | output | 32 | Table 1 word |
| s2_out | output | 32 | Table 2 word |
| s3_out | output | 32 | Table 3 word |
| f_out | output | 32 | Blowfish F value of the four words |
| out_valid | output | 1 | Outputs hold a lookup result |
| load_done | output | 1 | Pulse after the final table write |

## Verification
A loader that fills the wrong half-space or the wrong memory shows up at the next lookup. The affected word port then returns the staging word of another table or entry, and a byte pattern with four distinct indices exposes it. A misaligned pipeline-valid register or port multiplexer shows up within two cycles as a stray, missing or shifted out_valid, or as data from the previous strobe. A stale read counter shows up at once as a wrong stage_addr step, or as a done pulse that is early or late relative to the last read.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  parameter int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t bf_mix(word_t a, word_t b, word_t c, word_t d);
    return ((a + b) ^ c) + d;
  endfunction
endpackage

// File: rtl/sbox_dpram.sv
module sbox_dpram
  import sbox_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  word_t         a_wdata,
  output word_t         a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  word_t         b_wdata,
  output word_t         b_rdata
);
  localparam int DEPTH = 1 << AW;

  word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_wdata;
      b_rdata <= mem[b_addr];
    end
  end
endmodule

// File: rtl/sbox_loader.sv
module sbox_loader #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             start,
  output logic             stage_rd,
  output logic [IDX_W+1:0] stage_addr,
  output logic             wr_vld,
  output logic [IDX_W+1:0] wr_idx,
  output logic             busy,
  output logic             done
);
  localparam int CW = IDX_W + 2;
  localparam logic [CW-1:0] LAST = {CW{1'b1}};

  logic          issue_q, issue_n;
  logic [CW-1:0] rd_idx_q, rd_idx_n;
  logic          wv_q, wv_n;
  logic [CW-1:0] wi_q, wi_n;
  logic          done_q, done_n;

  always_comb begin
    issue_n  = issue_q;
    rd_idx_n = rd_idx_q;
    if (issue_q) begin
      rd_idx_n = rd_idx_q + 1'b1;
      if (rd_idx_q == LAST) issue_n = 1'b0;
    end else if (start && !wv_q) begin
      issue_n  = 1'b1;
      rd_idx_n = '0;
    end
    wv_n   = issue_q;
    wi_n   = rd_idx_q;
    done_n = wv_q && (wi_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      issue_q  <= 1'b0;
      rd_idx_q <= '0;
      wv_q     <= 1'b0;
      wi_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      issue_q  <= issue_n;
      rd_idx_q <= rd_idx_n;
      wv_q     <= wv_n;
      wi_q     <= wi_n;
      done_q   <= done_n;
    end
  end

  assign stage_rd   = issue_q;
  assign stage_addr = rd_idx_q;
  assign wr_vld     = wv_q;
  assign wr_idx     = wi_q;
  assign busy       = issue_q | wv_q;
  assign done       = done_q;
endmodule

// File: rtl/sbox_lookup_mem.sv
module sbox_lookup_mem
  import sbox_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lookup_strobe,
  input  logic [4*IDX_W-1:0]     round_in,
  input  logic                   load_start,
  output logic                   stage_rd,
  output logic [IDX_W+1:0]       stage_addr,
  input  word_t                  stage_data,
  output word_t                  s0_out,
  output word_t                  s1_out,
  output word_t                  s2_out,
  output word_t                  s3_out,
  output word_t                  f_out,
  output logic                   out_valid,
  output logic                   load_done
);
  localparam int AW = IDX_W + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic             ld_busy, ld_wv;
  logic [IDX_W+1:0] ld_idx;

  sbox_loader #(.IDX_W(IDX_W)) u_loader (
    .clk        (clk),
    .rst_q_n    (rst_q_n),
    .start      (load_start),
    .stage_rd   (stage_rd),
    .stage_addr (stage_addr),
    .wr_vld     (ld_wv),
    .wr_idx     (ld_idx),
    .busy       (ld_busy),
    .done       (load_done)
  );

  logic accept;
  assign accept = lookup_strobe & ~ld_busy;

  logic [1:0]       wr_tbl;
  logic [IDX_W-1:0] wr_ent;
  assign wr_tbl = ld_idx[IDX_W+1:IDX_W];
  assign wr_ent = ld_idx[IDX_W-1:0];

  word_t rd_a [2];
  word_t rd_b [2];

  // memory m: port A serves table 2m, port B serves table 2m+1
  for (genvar m = 0; m < 2; m++) begin : g_mem
    logic          we_a, we_b;
    logic [AW-1:0] addr_a, addr_b;
    assign we_a   = ld_wv && (wr_tbl == 2'(2*m));
    assign we_b   = ld_wv && (wr_tbl == 2'(2*m+1));
    assign addr_a = ld_busy ? {1'b0, wr_ent}
                            : {1'b0, round_in[(3-2*m)*IDX_W +: IDX_W]};
    assign addr_b = ld_busy ? {1'b1, wr_ent}
                            : {1'b1, round_in[(2-2*m)*IDX_W +: IDX_W]};

    sbox_dpram #(.AW(AW)) u_ram (
      .clk     (clk),
      .a_en    (accept | we_a),
      .a_we    (we_a),
      .a_addr  (addr_a),
      .a_wdata (stage_data),
      .a_rdata (rd_a[m]),
      .b_en    (accept | we_b),
      .b_we    (we_b),
      .b_addr  (addr_b),
      .b_wdata (stage_data),
      .b_rdata (rd_b[m])
    );
  end

  logic  rd_vld_q;
  logic  vld_q, vld_n;
  word_t s0_q, s1_q, s2_q, s3_q, f_q;
  word_t s0_n, s1_n, s2_n, s3_n, f_n;

  always_comb begin
    vld_n = rd_vld_q;
    s0_n  = rd_a[0];
    s1_n  = rd_b[0];
    s2_n  = rd_a[1];
    s3_n  = rd_b[1];
    f_n   = bf_mix(rd_a[0], rd_b[0], rd_a[1], rd_b[1]);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rd_vld_q <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      rd_vld_q <= accept;
      vld_q    <= vld_n;
    end
  end

  // data registers: enabled only when a read result is present
  always_ff @(posedge clk) begin
    if (rd_vld_q) begin
      s0_q <= s0_n;
      s1_q <= s1_n;
      s2_q <= s2_n;
      s3_q <= s3_n;
      f_q  <= f_n;
    end
  end

  assign s0_out    = s0_q;
  assign s1_out    = s1_q;
  assign s2_out    = s2_q;
  assign s3_out    = s3_q;
  assign f_out     = f_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/sbox_lookup_mem_chk.sv
module sbox_lookup_mem_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             lookup_strobe,
  input logic             stage_rd,
  input logic [IDX_W+1:0] stage_addr,
  input logic             out_valid,
  input logic             load_done,
  input logic             busy
);
  // R3
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid |-> $past(lookup_strobe, 2));

  // R8
  no_valid_in_load_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(busy, 2) |-> !out_valid);

  // R6
  addr_first_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(stage_rd) |-> (stage_addr == '0));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (stage_rd && $past(stage_rd)) |-> (stage_addr == $past(stage_addr) + 1'b1));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    load_done |=> !load_done);

  // R7
  done_after_reads_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    load_done |-> ($past(stage_rd, 2) && !$past(stage_rd)));
endmodule

bind sbox_lookup_mem sbox_lookup_mem_chk #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_q_n       (rst_q_n),
  .lookup_strobe (lookup_strobe),
  .stage_rd      (stage_rd),
  .stage_addr    (stage_addr),
  .out_valid     (out_valid),
  .load_done     (load_done),
  .busy          (ld_busy)
);

// File: tb/sbox_lookup_mem_tb.sv
module sbox_lookup_mem_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup_strobe = 1'b0;
  logic [31:0] round_in = '0;
  logic        load_start = 1'b0;
  logic        stage_rd;
  logic [9:0]  stage_addr;
  logic [31:0] stage_data;
  logic [31:0] s0_out, s1_out, s2_out, s3_out, f_out;
  logic        out_valid, load_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbox_lookup_mem u_dut (
    .clk(clk), .rst_n(rst_n), .lookup_strobe(lookup_strobe), .round_in(round_in),
    .load_start(load_start), .stage_rd(stage_rd), .stage_addr(stage_addr),
    .stage_data(stage_data), .s0_out(s0_out), .s1_out(s1_out), .s2_out(s2_out),
    .s3_out(s3_out), .f_out(f_out), .out_valid(out_valid), .load_done(load_done)
  );

  function automatic logic [31:0] stage_word(int i);
    logic [31:0] x;
    x = 32'(i) * 32'h9E37_79B9;
    return x ^ (32'(i) << 21) ^ 32'h5A3C_0F11;
  endfunction

  function automatic logic [31:0] tbl(int t, int e);
    return stage_word(t * 256 + e);
  endfunction

  // staging memory model: one-cycle read latency
  always @(posedge clk) if (stage_rd) stage_data <= stage_word(int'(stage_addr));

  typedef struct {
    logic [31:0] s0, s1, s2, s3, f;
    int stamp;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_addr = 0;
  int last_rd_cyc = -100;
  int done_cnt = 0;
  bit prev_done = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic lookup(logic [31:0] r);
    exp_t e;
    @(negedge clk);
    lookup_strobe = 1'b1;
    round_in = r;
    e.s0 = tbl(0, int'(r[31:24]));
    e.s1 = tbl(1, int'(r[23:16]));
    e.s2 = tbl(2, int'(r[15:8]));
    e.s3 = tbl(3, int'(r[7:0]));
    e.f  = ((e.s0 + e.s1) ^ e.s2) + e.s3;
    e.stamp = cyc;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lookup_strobe = 1'b0;
    end
  endtask

  // monitor: scoreboard for lookups, sequence checker for loads
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected out_valid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(cyc == e.stamp + 2, "R3", "latency cycle", 32'(cyc), 32'(e.stamp + 2));
          check(s0_out == e.s0, "R2", "s0 table0", s0_out, e.s0);
          check(s1_out == e.s1, "R2", "s1 table1", s1_out, e.s1);
          check(s2_out == e.s2, "R1", "s2 table2", s2_out, e.s2);
          check(s3_out == e.s3, "R1", "s3 table3", s3_out, e.s3);
          check(f_out == e.f, "R5", "f value", f_out, e.f);
        end
      end
      if (stage_rd) begin
        check(int'(stage_addr) == exp_addr, "R6", "stage_addr", 32'(stage_addr), 32'(exp_addr));
        if (exp_addr > 0)
          check(last_rd_cyc == cyc - 1, "R6", "consecutive reads", 32'(last_rd_cyc), 32'(cyc - 1));
        exp_addr++;
        last_rd_cyc = cyc;
      end
      if (load_done) begin
        done_cnt++;
        check(cyc == last_rd_cyc + 2, "R7", "done timing", 32'(cyc), 32'(last_rd_cyc + 2));
        check(exp_addr == NWORDS, "R7", "reads before done", 32'(exp_addr), 32'(NWORDS));
        check(!prev_done, "R7", "done width", 32'(prev_done), 32'd0);
      end
      prev_done = load_done;
    end
  end

  task automatic run_load();
    int start_cnt;
    start_cnt = done_cnt;
    exp_addr = 0;
    @(negedge clk);
    load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    idle(10);
    // R8: strobes during the load must be ignored
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      lookup_strobe = 1'b1;
      round_in = 32'h1234_5678 + 32'(i);
    end
    idle(300);
    // R10: restart attempt in the middle of the load
    @(negedge clk);
    load_start = 1'b1;
    @(negedge clk);
    load_start = 1'b0;
    while (done_cnt == start_cnt) @(negedge clk);
    check(done_cnt == start_cnt + 1, "R10", "single done per load", 32'(done_cnt), 32'(start_cnt + 1));
    check(exp_addr == NWORDS, "R10", "no restart of reads", 32'(exp_addr), 32'(NWORDS));
  endtask

  task automatic drain();
    idle(6);
    check(q.size() == 0, "R3", "pending results", 32'(q.size()), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(out_valid == 1'b0, "R9", "out_valid in reset", 32'(out_valid), 32'd0);
    check(load_done == 1'b0, "R9", "load_done in reset", 32'(load_done), 32'd0);
    check(stage_rd == 1'b0, "R9", "stage_rd in reset", 32'(stage_rd), 32'd0);
    rst_n = 1'b1;
    idle(5);

    run_load();
    idle(2);

    // single lookups with distinct patterns
    lookup(32'h0000_0000); idle(3);
    lookup(32'hFFFF_FFFF); idle(3);
    lookup(32'h0001_0203); idle(1);
    lookup(32'h80C0_E0F0); idle(2);

    // R4: back-to-back strobes
    for (int i = 0; i < 24; i++) lookup((32'(i) * 32'h0104_0A11) ^ 32'h3C5A_96E1);
    idle(1);
    lookup(32'hDEAD_BEEF);
    lookup(32'h0F1E_2D3C);
    drain();

    // R9: reset preserves tables
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid after reset", 32'(out_valid), 32'd0);
    check(load_done == 1'b0, "R9", "load_done after reset", 32'(load_done), 32'd0);
    rst_n = 1'b1;
    idle(5);
    lookup(32'hA55A_C33C);
    lookup(32'h7F80_01FE);
    drain();

    // second load then lookups again
    run_load();
    idle(2);
    lookup(32'h1122_3344);
    drain();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule